// File: doc/BRIEF.md
# Precise Exception Entry Controller

This block sequences exception and interrupt entry for a RISC core with delayed branching. The core keeps two program counters: `pc` is the address that will be fetched next, and `dpc` is the address of the instruction that is executing now. In every cycle the datapath hands over one step of work. That step carries the raw cause vector for the current instruction, the external request lines, whether an instruction was actually fetched, the control-flow outcome (taken flag and target), whether the instruction is a return-from-exception, and the fault data (trap immediate, effective address).

The controller merges the external lines into the cause vector and masks the maskable causes with the status register. If anything remains, it takes the jump-to-service-routine sequence:

- the status register is saved and then cleared;
- the effective causes are recorded;
- a program-counter pair is saved, either the current pair or the advanced pair depending on the kind of cause;
- a data word describing the fault is recorded;
- fetch is redirected to the fixed restart vector.

A return-from-exception restores the counters and the status register from the saved copies. Otherwise the counter pair advances in the normal delayed fashion. The datapath can also load the status register directly.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, `pc` is 4 and `dpc` is 0. `sr`, `esr`, `eca`, `epc`, `edpc` and `edata` are all 0, and `jisr` is low.
- R2: External request line k is ORed into cause bit 12+k before masking. Line 0 therefore lands on bit 12.
- R3: Cause bits 0 (reset), 1 (illegal), 2 (misaligned), 3 (fetch page fault), 4 (data page fault), 5 (trap) and 12 (FPU unimplemented) are never masked. Every other cause bit i counts only when `sr` bit i is 1. A masked cause changes nothing but the normal advance.
- R4: A step whose effective cause vector is nonzero takes an entry. In that case `eca` receives the effective vector, `esr` receives the `sr` value held before the step, `sr` becomes 0, and `jisr` is high in the following cycle only.
- R5: When any of causes 0 to 4 is present in the effective vector, the entry saves the current `pc` into `epc` and the current `dpc` into `edpc`.
- R6: Otherwise the entry saves the advanced pair. With a taken control flow change, `epc` gets the target and `edpc` gets the current `pc`. Without one, `epc` gets `pc`+4 and `edpc` gets the current `pc`.
- R7: `edata` is set on entry in this order of priority:
  - the current `dpc` when no instruction was fetched;
  - the zero-extended 26-bit trap immediate when trap (bit 5) is effective;
  - `eff_addr` when misaligned (bit 2) or data page fault (bit 4) is effective;
  - 0 in all other cases.
- R8: After an entry, `pc` is 4 and `dpc` is 0.
- R9: A return step without an effective cause loads `pc` from `epc`, `dpc` from `edpc` and `sr` from `esr`. If a return step also has an effective cause, the entry takes precedence.
- R10: A step that is neither an entry nor a return sets `dpc` to the old `pc`. It sets `pc` to the target when the control flow change is taken and an instruction was fetched, and to `pc`+4 otherwise.
- R11: `sr_load` writes `sr_load_val` into `sr` only on a step that is neither an entry nor a return. On other steps it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cause_raw | input | 32 | Raw cause vector from the datapath for this step |
| ext_req | input | EXT_W | External event request lines |
| fetched | input | 1 | An instruction was fetched this step |
| cfc_taken | input | 1 | Control flow change taken this step |
| cfc_target | input | 32 | Target of the control flow change |
| is_rfe | input | 1 | The instruction is a return-from-exception |
| trap_imm | input | 26 | Trap immediate field |
| eff_addr | input | 32 | Effective data address of the instruction |
| sr_load | input | 1 | Load the status register |
| sr_load_val | input | 32 | Value for the status register load |
| pc | output | 32 | Next fetch address |
| dpc | output | 32 | Address of the executing instruction |
| sr | output | 32 | Status (mask) register |
| esr | output | 32 | Saved status register |
| eca | output | 32 | Recorded effective causes |
| epc | output | 32 | Saved fetch address |
| edpc | output | 32 | Saved executing address |
| edata | output | 32 | Saved fault data |
| jisr | output | 1 | High for one cycle after an entry |

## Verification
The bench instantiates the block with EXT_W = 4, so external lines map onto cause bits 12 to 15. With four lines, one line falls on the non-maskable bit 12 and the others fall on maskable bits that the status register controls. This lets the bench drive both a line that can never be masked and lines that are masked or enabled through the mask. The width-32 defaults of the package put the non-maskable set, the repeat set and the restart vector at their fixed bit positions, so every `edata` source and both save variants can be reached with a few directed steps.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN       = 32;
    localparam int EXT_BASE   = 12;
    localparam int TRAP_IMM_W = 26;

    typedef logic [XLEN-1:0] word_t;

    typedef enum int unsigned {
        CI_RESET      = 0,
        CI_ILL        = 1,
        CI_MAL        = 2,
        CI_IPF        = 3,
        CI_DPF        = 4,
        CI_TRAP       = 5,
        CI_OVF        = 6,
        CI_FPU_UNIMPL = 12
    } cause_idx_e;

    function automatic word_t cause_bit(cause_idx_e idx);
        return word_t'(1) << idx;
    endfunction

    localparam word_t INSN_BYTES  = word_t'(4);
    localparam word_t RESTART_PC  = word_t'(4);
    localparam word_t RESTART_DPC = word_t'(0);

    localparam word_t NONMASK_SET = cause_bit(CI_RESET) | cause_bit(CI_ILL) |
                                    cause_bit(CI_MAL)   | cause_bit(CI_IPF) |
                                    cause_bit(CI_DPF)   | cause_bit(CI_TRAP) |
                                    cause_bit(CI_FPU_UNIMPL);

    localparam word_t REPEAT_SET  = cause_bit(CI_RESET) | cause_bit(CI_ILL) |
                                    cause_bit(CI_MAL)   | cause_bit(CI_IPF) |
                                    cause_bit(CI_DPF);

    localparam word_t ADDR_FAULT_SET = cause_bit(CI_MAL) | cause_bit(CI_DPF);

    typedef struct packed {
        word_t pc;
        word_t dpc;
    } pc_pair_t;

    typedef struct packed {
        word_t sr;
        word_t esr;
        word_t eca;
        word_t epc;
        word_t edpc;
        word_t edata;
    } spr_bank_t;

    typedef struct packed {
        logic  take;
        logic  rep;
        logic  has_trap;
        logic  has_addr_fault;
        word_t eff;
    } cause_info_t;

endpackage

// File: rtl/exc_cause_merge.sv
module exc_cause_merge
    import exc_pkg::*;
#(
    parameter int EXT_W = 20
) (
    input  word_t             raw,
    input  logic [EXT_W-1:0]  ext,
    input  word_t             sr,
    output cause_info_t       info
);
    localparam int EXT_TOP = EXT_BASE + EXT_W;

    word_t ext_wide;
    word_t merged;
    word_t eff;

    assign ext_wide = word_t'(ext) << EXT_BASE;
    assign merged   = raw | ext_wide;

    for (genvar g = 0; g < XLEN; g++) begin : g_mask
        assign eff[g] = merged[g] & (sr[g] | NONMASK_SET[g]);
    end

    always_comb begin
        info                = '0;
        info.eff            = eff;
        info.take           = |eff;
        info.rep            = |(eff & REPEAT_SET);
        info.has_trap       = eff[CI_TRAP];
        info.has_addr_fault = |(eff & ADDR_FAULT_SET);
    end

    initial begin
        if (EXT_TOP > XLEN) $error("external lines exceed cause width");
    end

endmodule

// File: rtl/exc_pc_step.sv
module exc_pc_step
    import exc_pkg::*;
(
    input  pc_pair_t cur,
    input  logic     fetched,
    input  logic     cfc_taken,
    input  word_t    cfc_target,
    output pc_pair_t adv
);
    logic redirect;

    assign redirect = cfc_taken & fetched;

    always_comb begin
        adv.dpc = cur.pc;
        adv.pc  = redirect ? cfc_target : (cur.pc + INSN_BYTES);
    end

endmodule

// File: rtl/exc_edata_sel.sv
module exc_edata_sel
    import exc_pkg::*;
(
    input  logic                  fetched,
    input  word_t                 cur_dpc,
    input  cause_info_t           info,
    input  logic [TRAP_IMM_W-1:0] trap_imm,
    input  word_t                 eff_addr,
    output word_t                 edata
);
    always_comb begin
        if (!fetched) begin
            edata = cur_dpc;
        end else if (info.has_trap) begin
            edata = word_t'(trap_imm);
        end else if (info.has_addr_fault) begin
            edata = eff_addr;
        end else begin
            edata = '0;
        end
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int EXT_W = 20
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [XLEN-1:0]       cause_raw,
    input  logic [EXT_W-1:0]      ext_req,
    input  logic                  fetched,
    input  logic                  cfc_taken,
    input  logic [XLEN-1:0]       cfc_target,
    input  logic                  is_rfe,
    input  logic [TRAP_IMM_W-1:0] trap_imm,
    input  logic [XLEN-1:0]       eff_addr,
    input  logic                  sr_load,
    input  logic [XLEN-1:0]       sr_load_val,
    output logic [XLEN-1:0]       pc,
    output logic [XLEN-1:0]       dpc,
    output logic [XLEN-1:0]       sr,
    output logic [XLEN-1:0]       esr,
    output logic [XLEN-1:0]       eca,
    output logic [XLEN-1:0]       epc,
    output logic [XLEN-1:0]       edpc,
    output logic [XLEN-1:0]       edata,
    output logic                  jisr
);
    pc_pair_t    pair_q, pair_n, adv_pair, saved_pair;
    spr_bank_t   spr_q, spr_n;
    logic        jisr_q, jisr_n;
    cause_info_t info;
    word_t       edata_sel;

    exc_cause_merge #(.EXT_W(EXT_W)) u_merge (
        .raw  (cause_raw),
        .ext  (ext_req),
        .sr   (spr_q.sr),
        .info (info)
    );

    exc_pc_step u_step (
        .cur        (pair_q),
        .fetched    (fetched),
        .cfc_taken  (cfc_taken),
        .cfc_target (cfc_target),
        .adv        (adv_pair)
    );

    exc_edata_sel u_edata (
        .fetched  (fetched),
        .cur_dpc  (pair_q.dpc),
        .info     (info),
        .trap_imm (trap_imm),
        .eff_addr (eff_addr),
        .edata    (edata_sel)
    );

    assign saved_pair = info.rep ? pair_q : adv_pair;

    always_comb begin
        pair_n = adv_pair;
        spr_n  = spr_q;
        jisr_n = 1'b0;
        if (info.take) begin
            pair_n.pc   = RESTART_PC;
            pair_n.dpc  = RESTART_DPC;
            spr_n.sr    = '0;
            spr_n.esr   = spr_q.sr;
            spr_n.eca   = info.eff;
            spr_n.epc   = saved_pair.pc;
            spr_n.edpc  = saved_pair.dpc;
            spr_n.edata = edata_sel;
            jisr_n      = 1'b1;
        end else if (is_rfe) begin
            pair_n.pc  = spr_q.epc;
            pair_n.dpc = spr_q.edpc;
            spr_n.sr   = spr_q.esr;
        end else if (sr_load) begin
            spr_n.sr = sr_load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q.pc  <= RESTART_PC;
            pair_q.dpc <= RESTART_DPC;
            spr_q      <= '0;
            jisr_q     <= 1'b0;
        end else begin
            pair_q <= pair_n;
            spr_q  <= spr_n;
            jisr_q <= jisr_n;
        end
    end

    assign pc    = pair_q.pc;
    assign dpc   = pair_q.dpc;
    assign sr    = spr_q.sr;
    assign esr   = spr_q.esr;
    assign eca   = spr_q.eca;
    assign epc   = spr_q.epc;
    assign edpc  = spr_q.edpc;
    assign edata = spr_q.edata;
    assign jisr  = jisr_q;

endmodule

module exc_entry_ctrl_chk
    import exc_pkg::*;
#(
    parameter int EXT_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic [XLEN-1:0]  cause_raw,
    input logic [EXT_W-1:0] ext_req,
    input logic             cfc_taken,
    input logic             is_rfe,
    input logic [XLEN-1:0]  pc,
    input logic [XLEN-1:0]  dpc,
    input logic [XLEN-1:0]  sr,
    input logic [XLEN-1:0]  esr,
    input logic [XLEN-1:0]  eca,
    input logic [XLEN-1:0]  epc,
    input logic [XLEN-1:0]  edpc,
    input logic             jisr
);
    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        jisr |-> (pc == 32'd4 && dpc == 32'd0));

    p_sr_clear_r4: assert property (@(posedge clk) disable iff (rst)
        jisr |-> (sr == 32'd0 && eca != 32'd0));

    p_esr_save_r4: assert property (@(posedge clk) disable iff (rst)
        (!rst && $rose(jisr)) |-> (esr == $past(sr)));

    p_nonmask_r3: assert property (@(posedge clk) disable iff (rst)
        ((cause_raw & 32'h0000_103F) != 32'd0) |=> jisr);

    p_repeat_r5: assert property (@(posedge clk) disable iff (rst)
        ((cause_raw & 32'h0000_001F) != 32'd0) |=> (epc == $past(pc) && edpc == $past(dpc)));

    p_rfe_r9: assert property (@(posedge clk) disable iff (rst)
        (is_rfe && cause_raw == 32'd0 && ext_req == '0)
        |=> (pc == $past(epc) && dpc == $past(edpc) && sr == $past(esr) && !jisr));

    p_advance_r10: assert property (@(posedge clk) disable iff (rst)
        (!is_rfe && !cfc_taken && cause_raw == 32'd0 && ext_req == '0)
        |=> (pc == $past(pc) + 32'd4 && dpc == $past(pc) && !jisr));

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.EXT_W(EXT_W)) u_chk (.*);

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb;

    localparam int EW = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] cause_raw;
    logic [EW-1:0] ext_req;
    logic        fetched;
    logic        cfc_taken;
    logic [31:0] cfc_target;
    logic        is_rfe;
    logic [25:0] trap_imm;
    logic [31:0] eff_addr;
    logic        sr_load;
    logic [31:0] sr_load_val;
    logic [31:0] pc, dpc, sr, esr, eca, epc, edpc, edata;
    logic        jisr;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    exc_entry_ctrl #(.EXT_W(EW)) u_dut (
        .clk(clk), .rst(rst), .cause_raw(cause_raw), .ext_req(ext_req),
        .fetched(fetched), .cfc_taken(cfc_taken), .cfc_target(cfc_target),
        .is_rfe(is_rfe), .trap_imm(trap_imm), .eff_addr(eff_addr),
        .sr_load(sr_load), .sr_load_val(sr_load_val),
        .pc(pc), .dpc(dpc), .sr(sr), .esr(esr), .eca(eca), .epc(epc),
        .edpc(edpc), .edata(edata), .jisr(jisr)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cause_raw = '0; ext_req = '0; fetched = 1'b1; cfc_taken = 1'b0;
        cfc_target = '0; is_rfe = 1'b0; trap_imm = '0; eff_addr = '0;
        sr_load = 1'b0; sr_load_val = '0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    task automatic chk_entry(input string req, input logic [31:0] x_eca,
                             input logic [31:0] x_esr, input logic [31:0] x_epc,
                             input logic [31:0] x_edpc, input logic [31:0] x_edata);
        chk(req, "jisr", {31'd0, jisr}, 32'd1);
        chk("R8", "pc", pc, 32'd4);
        chk("R8", "dpc", dpc, 32'd0);
        chk("R4", "sr", sr, 32'd0);
        chk(req, "eca", eca, x_eca);
        chk(req, "esr", esr, x_esr);
        chk(req, "epc", epc, x_epc);
        chk(req, "edpc", edpc, x_edpc);
        chk(req, "edata", edata, x_edata);
    endtask

    task automatic t_reset();
        rst = 1'b1; idle_inputs();
        repeat (3) @(posedge clk);
        #1; rst = 1'b0;
        chk("R1", "pc", pc, 32'd4);
        chk("R1", "dpc", dpc, 32'd0);
        chk("R1", "sr|esr|eca", sr | esr | eca, 32'd0);
        chk("R1", "epc|edpc|edata", epc | edpc | edata, 32'd0);
        chk("R1", "jisr", {31'd0, jisr}, 32'd0);
    endtask

    task automatic t_advance();
        step();
        chk("R10", "pc seq", pc, 32'h8);
        chk("R10", "dpc seq", dpc, 32'h4);
        cfc_taken = 1'b1; cfc_target = 32'h100; step();
        chk("R10", "pc taken", pc, 32'h100);
        chk("R10", "dpc taken", dpc, 32'h8);
        fetched = 1'b0; cfc_taken = 1'b1; cfc_target = 32'h500; step();
        chk("R10", "pc unfetched cfc", pc, 32'h104);
        chk("R10", "dpc unfetched cfc", dpc, 32'h100);
    endtask

    task automatic t_sr_load_and_maskable();
        sr_load = 1'b1; sr_load_val = 32'h40; step();
        chk("R11", "sr loaded", sr, 32'h40);
        chk("R11", "pc", pc, 32'h108);
        cause_raw = 32'h40; step();
        chk_entry("R6", 32'h40, 32'h40, 32'h10C, 32'h108, 32'h0);
        step();
        chk("R4", "jisr one cycle", {31'd0, jisr}, 32'd0);
        chk("R10", "pc after restart", pc, 32'h8);
    endtask

    task automatic t_masking();
        cause_raw = 32'h40; step();
        chk("R3", "masked ovf pc", pc, 32'hC);
        chk("R3", "masked ovf jisr", {31'd0, jisr}, 32'd0);
        ext_req = 4'b0010; step();
        chk("R3", "masked ext line 1 pc", pc, 32'h10);
        chk("R3", "masked ext eca kept", eca, 32'h40);
        ext_req = 4'b0001; step();
        chk_entry("R2", 32'h1000, 32'h0, 32'h14, 32'h10, 32'h0);
    endtask

    task automatic t_repeat();
        step();
        cause_raw = 32'h2; cfc_taken = 1'b1; cfc_target = 32'h200; step();
        chk_entry("R5", 32'h2, 32'h0, 32'h8, 32'h4, 32'h0);
    endtask

    task automatic t_edata();
        cause_raw = 32'h10; eff_addr = 32'hABCD0; step();
        chk_entry("R7", 32'h10, 32'h0, 32'h4, 32'h0, 32'hABCD0);
        cause_raw = 32'h20; trap_imm = 26'h2345678; eff_addr = 32'h55;
        cfc_taken = 1'b1; cfc_target = 32'h300; step();
        chk_entry("R7", 32'h20, 32'h0, 32'h300, 32'h4, 32'h02345678);
        step();
        fetched = 1'b0; cause_raw = 32'h8; step();
        chk_entry("R7", 32'h8, 32'h0, 32'h8, 32'h4, 32'h4);
    endtask

    task automatic t_rfe();
        step();
        sr_load = 1'b1; sr_load_val = 32'h80; step();
        chk("R11", "sr loaded 80", sr, 32'h80);
        cause_raw = 32'h80; step();
        chk_entry("R6", 32'h80, 32'h80, 32'h10, 32'hC, 32'h0);
        is_rfe = 1'b1; sr_load = 1'b1; sr_load_val = 32'h3; step();
        chk("R9", "pc from epc", pc, 32'h10);
        chk("R9", "dpc from edpc", dpc, 32'hC);
        chk("R11", "sr from esr not load", sr, 32'h80);
        is_rfe = 1'b1; cause_raw = 32'h2; step();
        chk_entry("R9", 32'h2, 32'h80, 32'h10, 32'hC, 32'h0);
    endtask

    task automatic t_late_lines();
        sr_load = 1'b1; sr_load_val = 32'hFF; cause_raw = 32'h1; step();
        chk("R11", "load ignored on entry", sr, 32'h0);
        sr_load = 1'b1; sr_load_val = 32'h8000; step();
        ext_req = 4'b1000; step();
        chk_entry("R2", 32'h8000, 32'h8000, 32'hC, 32'h8, 32'h0);
    endtask

    initial begin
        idle_inputs();
        rst = 1'b1;
        t_reset();
        t_advance();
        t_sr_load_and_maskable();
        t_masking();
        t_repeat();
        t_edata();
        t_rfe();
        t_late_lines();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule